// File: doc/BRIEF.md
# Edge-Detecting GPIO Controller with Grouped Interrupts

This block controls thirteen general-purpose pins from a byte-wide register bus. Each pin has two configuration bytes. The output-control byte holds the value to drive, the direction, the drive style (push-pull or open-drain) and a pull selection. The input-control byte returns the synchronized pin level and holds the edge-detect mode. The pins fall into banks of 7, 4 and 2. The first bank reports interrupts through group 0, and the other two banks share group 1.

Each pin level passes through a two-flop synchronizer. A selected edge of the synchronized level sets that pin's bit in its group's status register. Software clears a status bit by writing a one to it. A mask register per group decides which pending bits reach the single registered interrupt line. Drive style and pull selection only leave the block as configuration bits for the pad logic.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the following hold: every `pad_oe` bit is 0, every edge mode is disabled, both status registers read 0, mask group 0 reads 0x7F, mask group 1 reads 0x3F, and `irq_out` is 0.
- R2: Default address map: output-control byte of pin p at 0x20+p, input-control byte of pin p at 0x2D+p, status group 0/1 at 0x08/0x09, mask group 0/1 at 0x0A/0x0B. A read returns its data on `bus_rdata` one cycle after the strobe is sampled. An unmapped address reads 0.
- R3: Output-control byte layout:
  - bit 0 is the value;
  - bits 2:1 select the pull (0 strong down, 1 strong up, 2 weak down, 3 weak up) and appear on `pad_pull_sel`;
  - bit 3 enables the pull (`pad_pull_en`);
  - bit 4 selects push-pull when 1 (`pad_push_pull`);
  - bit 5 selects output when 1;
  - bits 7:6 read as 0.
- R4: Pin drive:
  - direction 0 gives `pad_oe`=0;
  - direction 1 with push-pull drives `pad_out` equal to bit 0 with `pad_oe`=1;
  - open-drain with value 1 gives `pad_oe`=0;
  - open-drain with value 0 gives `pad_oe`=1 and `pad_out`=0.
- R5: Input-control byte layout: bit 0 reads the level of the pin after a two-flop synchronizer, and writes to it are ignored. Bits 2:1 hold the edge mode (0 off, 1 falling, 2 rising, 3 both). Bits 7:3 read as 0.
- R6: A selected edge on pin p sets a status bit. For p below 7 it sets bit p of group 0; otherwise it sets bit p-7 of group 1. The bit is readable three clock edges after the pin change is sampled. An edge of the unselected polarity sets nothing.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R8: When an edge and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R9: Status bits are set regardless of the mask. A mask bit of 1 keeps its status bit from the interrupt line.
- R10: `irq_out` is a registered level. It equals the OR over both groups of status AND NOT mask, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 13 | Asynchronous pin levels |
| pad_out | output | 13 | Pin drive value |
| pad_oe | output | 13 | Pin output enable |
| pad_pull_en | output | 13 | Pull enable per pin |
| pad_pull_sel | output | 26 | Pull selection, two bits per pin |
| pad_push_pull | output | 13 | 1 push-pull, 0 open-drain |
| irq_out | output | 1 | Combined interrupt, active high |

## Verification
A register write shows on the pad outputs right after the edge that captures it. Read data comes on the edge that samples the strobe, and the bench compares it at the next falling edge.

A pin change made at a falling edge sets status three rising edges later, and `irq_out` follows one edge after that. The bench always waits at least that long before it reads status or samples the interrupt line.

The set-wins case is aligned exactly: the clearing write is placed so that it is captured on the same edge as the status set.

// File: rtl/gpioc_pkg.sv
package gpioc_pkg;
  localparam int OCTL_BITS = 6;
  localparam int MODE_BITS = 2;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_RISE = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_e;

  typedef struct packed {
    logic       dir_out;
    logic       push_pull;
    logic       pull_en;
    logic [1:0] pull_sel;
    logic       value;
  } octl_t;
endpackage

// File: rtl/gpioc_sync.sv
module gpioc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpioc_pin.sv
module gpioc_pin
  import gpioc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       octl_we,
  input  logic       ictl_we,
  input  logic [7:0] wdata,
  input  logic       pad_in,
  output octl_t      octl,
  output edge_mode_e mode,
  output logic       level,
  output logic       evt,
  output logic       pad_out,
  output logic       pad_oe
);
  logic prev;
  logic rise, fall;

  gpioc_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d(pad_in), .q(level)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      octl <= '0;
      mode <= EDGE_OFF;
      prev <= 1'b0;
    end else begin
      prev <= level;
      if (octl_we) octl <= octl_t'(wdata[OCTL_BITS-1:0]);
      if (ictl_we) mode <= edge_mode_e'(wdata[MODE_BITS:1]);
    end
  end

  assign rise = level & ~prev;
  assign fall = ~level & prev;
  assign evt  = (mode[1] & rise) | (mode[0] & fall);

  assign pad_oe  = octl.dir_out & (octl.push_pull | ~octl.value);
  assign pad_out = octl.value & octl.push_pull;

  a_r4_input_released : assert property (@(posedge clk) disable iff (rst)
    !octl.dir_out |-> !pad_oe);
  a_r4_od_high_released : assert property (@(posedge clk) disable iff (rst)
    (octl.dir_out && !octl.push_pull && octl.value) |-> !pad_oe);
  a_r5_off_no_event : assert property (@(posedge clk) disable iff (rst)
    (mode == EDGE_OFF) |-> !evt);
  a_r6_rise_only : assert property (@(posedge clk) disable iff (rst)
    (mode == EDGE_RISE && evt) |-> level);
endmodule

// File: rtl/gpioc_irq_group.sv
module gpioc_irq_group #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         clr_we,
  input  logic         mask_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] status,
  output logic [W-1:0] mask,
  output logic         pend
);
  logic [W-1:0] clr_bits;

  assign clr_bits = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      mask   <= '1;
    end else begin
      status <= (status & ~clr_bits) | evt;
      if (mask_we) mask <= wdata;
    end
  end

  assign pend = |(status & ~mask);

  a_r7_w1c_clears : assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((status & $past(wdata & ~evt)) == '0));
  a_r8_set_wins : assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((status & $past(evt)) == $past(evt)));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpioc_pkg::*;
#(
  parameter int NUM_PINS    = 13,
  parameter int GRP0_PINS   = 7,
  parameter int ADDR_W      = 8,
  parameter int OCTL_BASE   = 32,
  parameter int STAT_BASE   = 8,
  parameter int MASK_BASE   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [7:0]            bus_wdata,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  output logic [7:0]            bus_rdata,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [NUM_PINS-1:0]   pad_pull_en,
  output logic [2*NUM_PINS-1:0] pad_pull_sel,
  output logic [NUM_PINS-1:0]   pad_push_pull,
  output logic                  irq_out
);
  localparam int GRP1_PINS = NUM_PINS - GRP0_PINS;
  localparam int ICTL_BASE = OCTL_BASE + NUM_PINS;

  octl_t         octl_a  [NUM_PINS];
  edge_mode_e    mode_a  [NUM_PINS];
  logic [NUM_PINS-1:0] level, evt;
  logic [GRP0_PINS-1:0] stat0, mask0;
  logic [GRP1_PINS-1:0] stat1, mask1;
  logic pend0, pend1;
  logic [7:0] rd_nxt;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic ow, iw;
    assign ow = bus_wr && (bus_addr == ADDR_W'(OCTL_BASE + p));
    assign iw = bus_wr && (bus_addr == ADDR_W'(ICTL_BASE + p));

    gpioc_pin #(.SYNC_STAGES(SYNC_STAGES)) pin_i (
      .clk(clk), .rst(rst), .octl_we(ow), .ictl_we(iw), .wdata(bus_wdata),
      .pad_in(pad_in[p]), .octl(octl_a[p]), .mode(mode_a[p]),
      .level(level[p]), .evt(evt[p]), .pad_out(pad_out[p]), .pad_oe(pad_oe[p])
    );

    assign pad_pull_en[p]        = octl_a[p].pull_en;
    assign pad_pull_sel[2*p +: 2] = octl_a[p].pull_sel;
    assign pad_push_pull[p]      = octl_a[p].push_pull;
  end

  gpioc_irq_group #(.W(GRP0_PINS)) grp0_i (
    .clk(clk), .rst(rst), .evt(evt[GRP0_PINS-1:0]),
    .clr_we (bus_wr && bus_addr == ADDR_W'(STAT_BASE)),
    .mask_we(bus_wr && bus_addr == ADDR_W'(MASK_BASE)),
    .wdata(bus_wdata[GRP0_PINS-1:0]),
    .status(stat0), .mask(mask0), .pend(pend0)
  );

  gpioc_irq_group #(.W(GRP1_PINS)) grp1_i (
    .clk(clk), .rst(rst), .evt(evt[NUM_PINS-1:GRP0_PINS]),
    .clr_we (bus_wr && bus_addr == ADDR_W'(STAT_BASE + 1)),
    .mask_we(bus_wr && bus_addr == ADDR_W'(MASK_BASE + 1)),
    .wdata(bus_wdata[GRP1_PINS-1:0]),
    .status(stat1), .mask(mask1), .pend(pend1)
  );

  always_comb begin
    rd_nxt = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (bus_addr == ADDR_W'(OCTL_BASE + p)) rd_nxt = {2'b00, octl_a[p]};
      if (bus_addr == ADDR_W'(ICTL_BASE + p)) rd_nxt = {5'b0, mode_a[p], level[p]};
    end
    if (bus_addr == ADDR_W'(STAT_BASE))     rd_nxt = 8'(stat0);
    if (bus_addr == ADDR_W'(STAT_BASE + 1)) rd_nxt = 8'(stat1);
    if (bus_addr == ADDR_W'(MASK_BASE))     rd_nxt = 8'(mask0);
    if (bus_addr == ADDR_W'(MASK_BASE + 1)) rd_nxt = 8'(mask1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_nxt;
      irq_out <= pend0 | pend1;
    end
  end

  a_r10_irq_has_source : assert property (@(posedge clk) disable iff (rst)
    irq_out |-> ($past(|stat0) || $past(|stat1)));
  a_r9_masked_quiet : assert property (@(posedge clk) disable iff (rst)
    ((&mask0) && (&mask1)) |=> !irq_out);
endmodule

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0, bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [12:0] pad_in = '0;
  logic [12:0] pad_out, pad_oe, pad_pull_en, pad_push_pull;
  logic [25:0] pad_pull_sel;
  logic        irq_out;

  int checks = 0, fails = 0;
  bit done = 0;
  logic rd_d = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en),
    .pad_pull_sel(pad_pull_sel), .pad_push_pull(pad_push_pull), .irq_out(irq_out)
  );

  always @(posedge clk) rd_d <= bus_rd;

  // monitor: pops expected read data one cycle after each strobe
  initial forever begin
    @(negedge clk);
    if (rd_d && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        fails++;
        $display("FAIL %s: rdata=%02h expected %02h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", t, act, e);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pin(input int p, input logic v);
    @(negedge clk);
    pad_in[p] = v;
    waitc(5);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    waitc(3);
    rst = 1'b0;
    waitc(1);
    // R1 reset state
    chk(pad_oe, 0, "R1 pad_oe");
    chk(irq_out, 0, "R1 irq_out");
    rd(8'h0A, 8'h7F, "R1 mask0");
    rd(8'h0B, 8'h3F, "R1 mask1");
    rd(8'h08, 8'h00, "R1 status0");
    rd(8'h2D, 8'h00, "R1 ictl pin0");
    rd(8'h55, 8'h00, "R2 unmapped");

    // R3/R4 output control
    wr(8'h23, 8'h31);
    chk(pad_oe[3], 1, "R4 push-pull oe");
    chk(pad_out[3], 1, "R4 push-pull out");
    rd(8'h23, 8'h31, "R3 readback");
    wr(8'h24, 8'hFF);
    rd(8'h24, 8'h3F, "R3 upper bits zero");
    chk(pad_pull_en[4], 1, "R3 pull_en");
    chk(pad_pull_sel[9:8], 3, "R3 pull_sel");
    chk(pad_push_pull[4], 1, "R3 push_pull");
    wr(8'h25, 8'h21);
    chk(pad_oe[5], 0, "R4 od release");
    wr(8'h25, 8'h20);
    chk({pad_oe[5], pad_out[5]}, 2'b10, "R4 od drive low");
    wr(8'h25, 8'h11);
    chk(pad_oe[5], 0, "R4 input no drive");

    // R5 level and read-only bit
    set_pin(2, 1'b1);
    rd(8'h2F, 8'h01, "R5 level");
    wr(8'h2F, 8'h00);
    rd(8'h2F, 8'h01, "R5 level write ignored");
    wr(8'h2F, 8'h06);
    rd(8'h2F, 8'h07, "R5 mode readback");

    // R6/R10 rising on pin1
    wr(8'h0A, 8'h00);
    wr(8'h0B, 8'h00);
    wr(8'h2E, 8'h04);
    set_pin(1, 1'b1);
    rd(8'h08, 8'h02, "R6 rise pin1");
    chk(irq_out, 1, "R10 irq set");
    wr(8'h08, 8'h00);
    rd(8'h08, 8'h02, "R7 zero write keeps");
    wr(8'h08, 8'h02);
    rd(8'h08, 8'h00, "R7 one clears");
    chk(irq_out, 0, "R10 irq cleared");
    set_pin(1, 1'b0);
    rd(8'h08, 8'h00, "R6 falling ignored in rise mode");

    // R6 falling on pin12
    wr(8'h39, 8'h02);
    set_pin(12, 1'b1);
    rd(8'h09, 8'h00, "R6 rise ignored in fall mode");
    set_pin(12, 1'b0);
    rd(8'h09, 8'h20, "R6 fall pin12 group1 bit5");
    wr(8'h09, 8'h20);

    // R6 both edges on pin8
    wr(8'h35, 8'h06);
    set_pin(8, 1'b1);
    rd(8'h09, 8'h02, "R6 both rise pin8");
    wr(8'h09, 8'h02);
    set_pin(8, 1'b0);
    rd(8'h09, 8'h02, "R6 both fall pin8");
    wr(8'h09, 8'h02);

    // R9 mask
    wr(8'h0B, 8'h3F);
    set_pin(8, 1'b1);
    rd(8'h09, 8'h02, "R9 status set while masked");
    chk(irq_out, 0, "R9 masked irq low");

    // R8 set wins: clear write captured on the edge that sets status
    @(negedge clk);
    pad_in[8] = 1'b0;
    @(posedge clk);
    @(posedge clk);
    wr(8'h09, 8'h02);
    rd(8'h09, 8'h02, "R8 set wins");

    wr(8'h0B, 8'h00);
    waitc(2);
    chk(irq_out, 1, "R9 unmask raises irq");

    waitc(4);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule